// File: doc/BRIEF.md
# Processor Halting Debug Controller

This block decides when a processor core has to stop and enter debug state, and when it may leave again. A debugger reaches it through a debug-port register interface. Through that interface the debugger writes a control/status register, sends halt and restart commands, supplies instructions to be run by the stopped core, and exchanges 32-bit words with the core through a shared transfer register. On the core side the block takes four event inputs, an asynchronous external debug request and a permission signal. It returns a halt request and an instruction-injection path, and it reads back the core's halted acknowledge.

Halting is armed only when three things are true: a mode bit that only the debug port can write is set, the enable input is high, and the core reports that debug is currently permitted. Any of six event sources can then halt the core, and the block latches a reason code for the event that did it. The only way out of debug state is a restart command. A status flag reports that the core has really resumed running. This flag is set on the core's acknowledge, not when the command is sent.

Top module: `halt_dbg_ctrl`

## Requirements
- R1: A debug-port write to the control register (`dp_csr_we`) loads `dp_wdata[14]` into the halt-mode bit. The bit reads back at `dp_csr_rdata[14]`, and the write works whether the core is halted or running.
- R2: A core-side control-register write (`core_csr_we`) leaves the halt-mode bit unchanged.
- R3: When halt mode is set, `dbg_enable` is high and `core_dbg_permit` is high, any of the events halt command, breakpoint, watchpoint, software breakpoint or vector catch, present at a clock edge while the core is not in debug state, raises `halt_req` after that edge.
- R4: If halt mode is clear, `dbg_enable` is low or `core_dbg_permit` is low, no event raises `halt_req`.
- R5: On entry the reason field `dp_csr_rdata[5:2]` is loaded with a code: 0 halt command, 1 breakpoint, 2 watchpoint, 3 software breakpoint, 4 external request, 5 vector catch. If several events coincide, the lowest code is used.
- R6: A halt command while already in debug state is ignored: `halt_req` stays high and the reason field is unchanged.
- R7: `inject_valid` follows `dp_instr_valid` (with `inject_instr` equal to `dp_instr`) only while `halt_req` and `core_halted_ack` are both high. Otherwise it is low.
- R8: `halt_req` drops only after a `dp_restart_cmd` seen while `core_halted_ack` is high. A restart command while the acknowledge is low is ignored.
- R9: The restarted flag `dp_csr_rdata[1]` is cleared on debug entry. It is set at the first edge, after an accepted restart, at which `core_halted_ack` is low.
- R10: The transfer register can be written from the debug port (`dp_dtr_we`) and from the core (`core_dtr_we`), and both sides read it. If both write in the same cycle, the debug-port value is kept.
- R11: `dp_csr_rdata[0]` follows `core_halted_ack` in the same cycle.
- R12: `ext_dbgrq` passes through a two-flop synchronizer, so `halt_req` rises at the third clock edge that sees the request, with reason 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_csr_we | input | 1 | Debug-port write strobe for the control register |
| dp_dtr_we | input | 1 | Debug-port write strobe for the transfer register |
| dp_wdata | input | 32 | Debug-port write data |
| dp_halt_cmd | input | 1 | Halt command pulse |
| dp_restart_cmd | input | 1 | Restart command pulse |
| dp_instr_valid | input | 1 | Debugger-supplied instruction is valid |
| dp_instr | input | 32 | Debugger-supplied instruction |
| dp_csr_rdata | output | 32 | Control/status readback |
| dp_dtr_rdata | output | 32 | Transfer register readback (debug port) |
| core_csr_we | input | 1 | Core-side control-register write strobe |
| core_dtr_we | input | 1 | Core-side transfer register write strobe |
| core_wdata | input | 32 | Core-side write data |
| core_dtr_rdata | output | 32 | Transfer register readback (core) |
| dbg_enable | input | 1 | Debug enabled |
| core_dbg_permit | input | 1 | Core reports debug is currently permitted |
| ev_bkpt | input | 1 | Breakpoint hit |
| ev_wpt | input | 1 | Watchpoint hit |
| ev_swbkpt | input | 1 | Software breakpoint executed |
| ev_vcatch | input | 1 | Vector catch |
| ext_dbgrq | input | 1 | Asynchronous external debug request (level) |
| core_halted_ack | input | 1 | Core reports it is halted |
| halt_req | output | 1 | Request to core to stop and stay in debug state |
| inject_valid | output | 1 | Injected instruction valid |
| inject_instr | output | 32 | Injected instruction |

## Verification
Random event vectors are applied under random combinations of mode, enable and permission. This separates the gate that allows entry from the priority encoder that picks the reason, because both the halt decision and the code are predicted from the same vector. Directed single-event cases confirm each code alone. A delayed external request exposes the two extra synchronizer cycles. Restart is tried with the acknowledge low and with it high, which shows whether the flag waits for the core to resume and not for the command. Writes that coincide on both sides of the transfer register, and core writes to the control register, show which side wins.

// File: rtl/halt_dbg_ctrl.sv
module halt_dbg_ctrl #(
  parameter int DW = 32,
  parameter int MODE_BIT = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_csr_we,
  input  logic          dp_dtr_we,
  input  logic [DW-1:0] dp_wdata,
  input  logic          dp_halt_cmd,
  input  logic          dp_restart_cmd,
  input  logic          dp_instr_valid,
  input  logic [DW-1:0] dp_instr,
  output logic [DW-1:0] dp_csr_rdata,
  output logic [DW-1:0] dp_dtr_rdata,
  input  logic          core_csr_we,
  input  logic          core_dtr_we,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_dtr_rdata,
  input  logic          dbg_enable,
  input  logic          core_dbg_permit,
  input  logic          ev_bkpt,
  input  logic          ev_wpt,
  input  logic          ev_swbkpt,
  input  logic          ev_vcatch,
  input  logic          ext_dbgrq,
  input  logic          core_halted_ack,
  output logic          halt_req,
  output logic          inject_valid,
  output logic [DW-1:0] inject_instr
);
  localparam int NEV = 6;
  localparam int RW = 4;

  logic                   halt_mode;
  logic                   restarted;
  logic                   rst_pend;
  logic [RW-1:0]          reason;
  logic [DW-1:0]          dtr;
  logic [SYNC_STAGES-1:0] ext_sync;
  logic [NEV-1:0]         ev;
  logic [RW-1:0]          ev_code;
  logic                   armed;
  logic                   enter;
  logic                   leave;

  assign ev = {ev_vcatch, ext_sync[SYNC_STAGES-1], ev_swbkpt, ev_wpt, ev_bkpt, dp_halt_cmd};

  always_comb begin
    ev_code = '0;
    for (int i = NEV - 1; i >= 0; i--)
      if (ev[i]) ev_code = RW'(i);
  end

  assign armed = halt_mode && dbg_enable && core_dbg_permit;
  assign enter = !halt_req && armed && (|ev);
  assign leave = halt_req && dp_restart_cmd && core_halted_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_dbgrq};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_mode <= 1'b0;
      halt_req  <= 1'b0;
      reason    <= '0;
      restarted <= 1'b0;
      rst_pend  <= 1'b0;
    end else begin
      if (dp_csr_we) halt_mode <= dp_wdata[MODE_BIT];
      if (enter) begin
        halt_req  <= 1'b1;
        reason    <= ev_code;
        restarted <= 1'b0;
        rst_pend  <= 1'b0;
      end else if (leave) begin
        halt_req <= 1'b0;
        rst_pend <= 1'b1;
      end else if (rst_pend && !core_halted_ack) begin
        restarted <= 1'b1;
        rst_pend  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dtr <= '0;
    else if (dp_dtr_we)   dtr <= dp_wdata;
    else if (core_dtr_we) dtr <= core_wdata;
  end

  always_comb begin
    dp_csr_rdata           = '0;
    dp_csr_rdata[MODE_BIT] = halt_mode;
    dp_csr_rdata[5:2]      = reason;
    dp_csr_rdata[1]        = restarted;
    dp_csr_rdata[0]        = core_halted_ack;
  end

  assign dp_dtr_rdata   = dtr;
  assign core_dtr_rdata = dtr;
  assign inject_valid   = dp_instr_valid && halt_req && core_halted_ack;
  assign inject_instr   = dp_instr;

  a_r2_core_write_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (core_csr_we && !dp_csr_we) |=> $stable(halt_mode));
  a_r4_entry_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(halt_mode && dbg_enable && core_dbg_permit));
  a_r6_reason_held: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && $past(halt_req)) |-> $stable(reason));
  a_r8_exit_by_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req) |-> $past(dp_restart_cmd && core_halted_ack));
  a_r9_flag_cleared_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> !restarted);
  a_r9_flag_waits_for_core: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restarted) |-> $past(!core_halted_ack && !halt_req));
endmodule

// File: tb/halt_dbg_ctrl_bench.sv
module halt_dbg_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic dp_csr_we = 0, dp_dtr_we = 0, dp_halt_cmd = 0, dp_restart_cmd = 0, dp_instr_valid = 0;
  logic [31:0] dp_wdata = 0, dp_instr = 0, core_wdata = 0;
  logic core_csr_we = 0, core_dtr_we = 0, dbg_enable = 0, core_dbg_permit = 0;
  logic ev_bkpt = 0, ev_wpt = 0, ev_swbkpt = 0, ev_vcatch = 0, ext_dbgrq = 0, core_halted_ack = 0;
  logic [31:0] dp_csr_rdata, dp_dtr_rdata, core_dtr_rdata, inject_instr;
  logic halt_req, inject_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  halt_dbg_ctrl u_halt_dbg_ctrl (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_reason(logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_mode(bit m);
    dp_csr_we = 1; dp_wdata = m ? 32'h4000 : 32'h0;
    tick();
    dp_csr_we = 0; dp_wdata = 0;
  endtask

  task automatic apply_events(logic [5:0] v);
    dp_halt_cmd = v[0]; ev_bkpt = v[1]; ev_wpt = v[2]; ev_swbkpt = v[3]; ev_vcatch = v[5];
    tick();
    dp_halt_cmd = 0; ev_bkpt = 0; ev_wpt = 0; ev_swbkpt = 0; ev_vcatch = 0;
  endtask

  task automatic do_restart(string tag);
    core_halted_ack = 1; tick();
    dp_restart_cmd = 1; tick();
    dp_restart_cmd = 0;
    check({tag, " R8 halt_req drops"}, halt_req, 0);
    check({tag, " R9 flag waits for core"}, dp_csr_rdata[1], 0);
    core_halted_ack = 0; tick();
    check({tag, " R9 flag set after resume"}, dp_csr_rdata[1], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); tick(); rst_n = 1; tick();
    check("reset halt_req", halt_req, 0);
    check("reset csr R11", dp_csr_rdata, 0);
    check("reset dtr R10", dp_dtr_rdata, 0);

    set_mode(1);
    check("R1 mode bit set", dp_csr_rdata[14], 1);
    core_csr_we = 1; core_wdata = 0; tick(); core_csr_we = 0;
    check("R2 core write ignored", dp_csr_rdata[14], 1);

    dbg_enable = 1; core_dbg_permit = 1;
    for (int i = 0; i < 6; i++) begin
      if (i == 4) continue;
      apply_events(6'(1 << i));
      check("R3 single event halts", halt_req, 1);
      check("R5 single code", dp_csr_rdata[5:2], 4'(i));
      check("R9 flag cleared", dp_csr_rdata[1], 0);
      do_restart("single");
    end

    apply_events(6'b000010);
    core_halted_ack = 1; dp_instr_valid = 1; dp_instr = 32'hCAFE0001;
    #1;
    check("R7 inject while halted", {inject_valid, inject_instr[30:0]}, {1'b1, 31'h4AFE0001});
    check("R11 halted bit follows ack", dp_csr_rdata[0], 1);
    dp_halt_cmd = 1; tick(); dp_halt_cmd = 0;
    check("R6 halt while halted", {halt_req, 27'd0, dp_csr_rdata[5:2]}, {1'b1, 27'd0, 4'd1});
    set_mode(1);
    check("R1 write while halted", dp_csr_rdata[14], 1);
    core_halted_ack = 0; #1;
    check("R7 no inject without ack", inject_valid, 0);
    dp_instr_valid = 0;
    dp_restart_cmd = 1; tick(); dp_restart_cmd = 0;
    check("R8 restart ignored ack low", halt_req, 1);
    do_restart("after ignored");
    dp_instr_valid = 1; #1;
    check("R7 no inject when running", inject_valid, 0);
    dp_instr_valid = 0;

    ext_dbgrq = 1; tick();
    check("R12 sync stage 1", halt_req, 0);
    tick();
    check("R12 sync stage 2", halt_req, 0);
    tick();
    ext_dbgrq = 0;
    check("R12 halt after sync", halt_req, 1);
    check("R5 ext code", dp_csr_rdata[5:2], 4);
    do_restart("ext");
    tick(); tick();

    dp_dtr_we = 1; dp_wdata = 32'h11112222; core_dtr_we = 1; core_wdata = 32'h33334444; tick();
    dp_dtr_we = 0; core_dtr_we = 0;
    check("R10 dp wins", core_dtr_rdata, 32'h11112222);
    core_dtr_we = 1; tick(); core_dtr_we = 0;
    check("R10 core write", dp_dtr_rdata, 32'h33334444);

    for (int n = 0; n < 300; n++) begin
      logic [5:0] v;
      logic m, e, p, exp_h;
      v = 6'($urandom) & 6'b101111;
      m = 1'($urandom); e = 1'($urandom); p = 1'($urandom);
      if (n % 4 == 0) begin m = 1; e = 1; p = 1; end
      set_mode(m); dbg_enable = e; core_dbg_permit = p;
      exp_h = m && e && p && (|v);
      apply_events(v);
      check(exp_h ? "R3 random halt" : "R4 random no halt", halt_req, exp_h);
      if (exp_h) begin
        check("R5 random priority", dp_csr_rdata[5:2], exp_reason(v));
        do_restart("random");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule